// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns the bus requests of a small 8-bit controller core into timed cycles on a shared external bus. A single 8-bit bus first carries the low address bits and then the data byte. A latch strobe marks the address phase so that outside latches can capture it on its falling edge. Separate active-low strobes qualify instruction fetches, data reads and data writes. During a fetch from external program memory, a 4-bit side port drives the top bits of the 12-bit program address.

Every machine cycle lasts 5 states of `CPS` clocks each, 15 clocks by default. The latch strobe pulses in every cycle, with or without a transfer, so outside logic can also use it as a clock. The core presents its next request while `take` is high and the request is captured on that edge. The cycle that follows carries it out. A request flagged as the last cycle of an instruction makes the sequencer halt after it while the single-step input is low. A halted sequencer stays idle until that input goes high.

Top module: `xbus_seq`

## Requirements
- R1: Outside a halt, `ale` is high for exactly the first `CPS` clocks (t = 0..CPS-1) of every 5*CPS-clock machine cycle, whatever the request kind, and low for the rest of the cycle.
- R2: `take` is high for one clock at t = 5*CPS-1 (and, when halted, in any clock where `step_n` is high). The request inputs sampled on that edge are carried out in the next machine cycle. Request kind codes: 0 none, 1 fetch, 2 data read, 3 data write.
- R3: A fetch is external when `ext_all` is high or the program address is 1024 or more. For an external fetch, `ad_oe` is high with `ad_out` equal to address bits [7:0] for t = 0..2*CPS-1. `hi_oe` is high with `hi_addr` equal to address bits [11:8] for the whole cycle. `pstore_n` is low for t = 2*CPS..4*CPS-1.
- R4: A fetch with `ext_all` low and a program address below 1024 produces no strobe other than `ale`, and leaves `ad_oe` and `hi_oe` low.
- R5: `pstore_n` is never low during a data read or write cycle, and `hi_oe` is high only during external fetches.
- R6: A data read drives the data address on `ad_out` for t = 0..2*CPS-1 and then releases the bus. `rd_n` is low for t = 2*CPS..4*CPS-1. The `ad_in` value present at t = 4*CPS-1 appears on `rd_data` with `rd_valid` high for the single clock t = 4*CPS. External fetches return their byte the same way.
- R7: A data write drives the address for t = 0..2*CPS-2 and the write data for t = 2*CPS-1..4*CPS, which is one clock before `wr_n` falls through one clock after it rises. `wr_n` is low for t = 2*CPS..4*CPS-1, and the bus is released afterwards.
- R8: When a cycle whose request had `req_last` high ends while `step_n` is low, `held` goes high. While held, no cycles run: `ale` stays low, all strobes stay high, and `ad_oe`, `hi_oe` and `take` stay low. The first clock with `step_n` high takes the next request, and a new cycle starts at t = 0.
- R9: At most one of `pstore_n`, `rd_n` and `wr_n` is low in any clock, and none is low outside t = 2*CPS..4*CPS-1.
- R10: While `rst_n` is low, all strobes except `ale` are high, `ad_oe`, `hi_oe`, `take`, `held` and `rd_valid` are low, and the first cycle after reset carries no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_kind | input | 2 | Next request: 0 none, 1 fetch, 2 read, 3 write |
| req_paddr | input | 12 | Program address for a fetch |
| req_daddr | input | 8 | Data memory address |
| req_wdata | input | 8 | Write data |
| req_last | input | 1 | Request is the final cycle of an instruction |
| ext_all | input | 1 | Send every fetch to external memory |
| step_n | input | 1 | Single-step control, active low |
| ad_in | input | 8 | Value read from the multiplexed bus |
| take | output | 1 | Request inputs are captured on this edge |
| held | output | 1 | Sequencer halted by single step |
| ale | output | 1 | Address latch strobe |
| pstore_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Value driven on the multiplexed bus |
| ad_oe | output | 1 | Bus drive enable |
| hi_addr | output | 4 | Program address bits [11:8] |
| hi_oe | output | 1 | Drive enable for hi_addr |
| rd_data | output | 8 | Byte captured at the end of a read or fetch |
| rd_valid | output | 1 | rd_data updated this clock |

## Verification
The final tick of a machine cycle is where request capture and the single-step halt decision meet. In that clock, `step_n` and `req_last` decide whether `take` fires or the sequencer goes idle. The bench lowers `step_n` while instruction-ending requests are in flight, releases it after a hold, and also gives it a short low pulse, so the step input changes both at a cycle end and in the middle of a cycle. A behavioural model tracks the cycle position, the halt state and the request queue. Every clock, it predicts `take`, `held`, each strobe and the bus contents, and these are compared against the design.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int CPS       = 3,
  parameter int AW        = 12,
  parameter int INT_WORDS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_paddr,
  input  logic [7:0]    req_daddr,
  input  logic [7:0]    req_wdata,
  input  logic          req_last,
  input  logic          ext_all,
  input  logic          step_n,
  input  logic [7:0]    ad_in,
  output logic          take,
  output logic          held,
  output logic          ale,
  output logic          pstore_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [7:0]    ad_out,
  output logic          ad_oe,
  output logic [AW-9:0] hi_addr,
  output logic          hi_oe,
  output logic [7:0]    rd_data,
  output logic          rd_valid
);
  localparam int MC = 5 * CPS;
  localparam int TW = $clog2(MC);
  localparam logic [TW-1:0] T_LAST    = TW'(MC - 1);
  localparam logic [TW-1:0] T_ALE_END = TW'(CPS);
  localparam logic [TW-1:0] T_WD      = TW'(2 * CPS - 1);
  localparam logic [TW-1:0] T_STB     = TW'(2 * CPS);
  localparam logic [TW-1:0] T_SMP     = TW'(4 * CPS - 1);
  localparam logic [TW-1:0] T_STB_END = TW'(4 * CPS);
  localparam logic [AW-1:0] INT_LIM   = AW'(INT_WORDS);
  localparam logic [1:0] K_NONE = 2'd0, K_FETCH = 2'd1, K_RD = 2'd2, K_WR = 2'd3;

  logic [TW-1:0] tcnt;
  logic          halt;
  logic [1:0]    cur_kind;
  logic [AW-1:0] cur_pa;
  logic [7:0]    cur_da, cur_wd;
  logic          cur_last, cur_ext;

  wire run       = !halt;
  wire ext_fetch = (cur_kind == K_FETCH) && (cur_ext || cur_pa >= INT_LIM);
  wire is_rd     = (cur_kind == K_RD);
  wire is_wr     = (cur_kind == K_WR);
  wire reads     = ext_fetch || is_rd;
  wire stb_win   = run && (tcnt >= T_STB) && (tcnt < T_STB_END);
  wire at_end    = run && (tcnt == T_LAST);
  wire go_halt   = at_end && !step_n && cur_last;
  wire sample    = run && (tcnt == T_SMP) && reads;

  assign take     = (at_end && !go_halt) || (halt && step_n);
  assign held     = halt;
  assign ale      = run && (tcnt < T_ALE_END);
  assign pstore_n = !(stb_win && ext_fetch);
  assign rd_n     = !(stb_win && is_rd);
  assign wr_n     = !(stb_win && is_wr);
  assign hi_oe    = run && ext_fetch;
  assign hi_addr  = cur_pa[AW-1:8];
  assign ad_oe    = run && ((reads && tcnt < T_STB) || (is_wr && tcnt <= T_STB_END));
  assign ad_out   = (is_wr && tcnt >= T_WD) ? cur_wd
                  : (cur_kind == K_FETCH)   ? cur_pa[7:0] : cur_da;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt     <= '0;
      halt     <= 1'b0;
      cur_kind <= K_NONE;
      cur_pa   <= '0;
      cur_da   <= '0;
      cur_wd   <= '0;
      cur_last <= 1'b0;
      cur_ext  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= sample;
      if (sample) rd_data <= ad_in;
      if (run && !at_end) tcnt <= tcnt + 1'b1;
      else tcnt <= '0;
      if (go_halt) begin
        halt     <= 1'b1;
        cur_kind <= K_NONE;
      end
      if (take) begin
        halt     <= 1'b0;
        cur_kind <= req_kind;
        cur_pa   <= req_paddr;
        cur_da   <= req_daddr;
        cur_wd   <= req_wdata;
        cur_last <= req_last;
        cur_ext  <= ext_all;
      end
    end
  end
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int CPS = 3,
  parameter int AW  = 12
) (
  input logic clk,
  input logic rst_n,
  input logic take,
  input logic held,
  input logic ale,
  input logic pstore_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic hi_oe,
  input logic rd_valid
);
  a_r1_ale_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);
  a_r2_take_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  a_r3_high_bits_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !pstore_n |-> hi_oe);
  a_r5_no_high_bits_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !hi_oe);
  a_r6_valid_at_read_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> rd_valid);
  a_r7_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(ad_oe));
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);
  a_r8_quiet_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (!ale && !ad_oe && !hi_oe && pstore_n && rd_n && wr_n));
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~pstore_n, ~rd_n, ~wr_n}) <= 1);
  a_r9_no_strobe_with_ale: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (pstore_n && rd_n && wr_n));
endmodule

bind xbus_seq xbus_seq_chk #(.CPS(CPS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .held(held), .ale(ale),
  .pstore_n(pstore_n), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
  .hi_oe(hi_oe), .rd_valid(rd_valid));

// File: tb/xbus_seq_bench.sv
module xbus_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPS = 3;
  localparam int MC  = 5 * CPS;
  localparam int NS  = 14;
  localparam int RUN_CYCLES = 420;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n;
  logic [1:0] req_kind;
  logic [11:0] req_paddr;
  logic [7:0] req_daddr, req_wdata, ad_in;
  logic req_last, ext_all, step_n;
  logic take, held, ale, pstore_n, rd_n, wr_n, ad_oe, hi_oe, rd_valid;
  logic [7:0] ad_out, rd_data;
  logic [3:0] hi_addr;

  xbus_seq #(.CPS(CPS)) u_xbus_seq (
    .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_paddr(req_paddr),
    .req_daddr(req_daddr), .req_wdata(req_wdata), .req_last(req_last),
    .ext_all(ext_all), .step_n(step_n), .ad_in(ad_in), .take(take),
    .held(held), .ale(ale), .pstore_n(pstore_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr), .hi_oe(hi_oe),
    .rd_data(rd_data), .rd_valid(rd_valid));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  int s_kind[NS], s_pa[NS], s_da[NS], s_wd[NS], s_last[NS], s_ext[NS];
  int sidx = 0;

  int m_t, m_kind, m_pa, m_da, m_wd, m_rdd;
  bit m_halt, m_last, m_ext, m_rdv;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic add(input int i, input int k, input int pa, input int da,
                     input int wd, input int last, input int ext);
    s_kind[i] = k; s_pa[i] = pa; s_da[i] = da; s_wd[i] = wd;
    s_last[i] = last; s_ext[i] = ext;
  endtask

  task automatic drive();
    if (sidx < NS) begin
      req_kind  = 2'(s_kind[sidx]);
      req_paddr = 12'(s_pa[sidx]);
      req_daddr = 8'(s_da[sidx]);
      req_wdata = 8'(s_wd[sidx]);
      req_last  = s_last[sidx] != 0;
      ext_all   = s_ext[sidx] != 0;
    end else begin
      req_kind = 2'd0; req_last = 1'b0; ext_all = 1'b0;
    end
    step_n = !((cyc >= 190 && cyc < 240) || (cyc >= 300 && cyc < 303));
    ad_in  = 8'(cyc * 37 + 11);
  endtask

  function automatic bit ext_f();
    return m_kind == 1 && (m_ext || m_pa >= 1024);
  endfunction

  task automatic compare();
    bit run, win, ef, rd, wr, e_take, e_oe;
    int e_out;
    run = !m_halt;
    win = run && m_t >= 2 * CPS && m_t < 4 * CPS;
    ef  = ext_f();
    rd  = m_kind == 2;
    wr  = m_kind == 3;
    e_take = (run && m_t == MC - 1 && !(!step_n && m_last)) || (m_halt && step_n);
    e_oe = run && (((ef || rd) && m_t < 2 * CPS) || (wr && m_t <= 4 * CPS));
    chk("R1 ale", int'(ale), int'(run && m_t < CPS));
    chk("R2 take", int'(take), int'(e_take));
    chk("R8 held", int'(held), int'(m_halt));
    chk("R3/R4/R5/R9 pstore_n", int'(pstore_n), int'(!(win && ef)));
    chk("R6/R9 rd_n", int'(rd_n), int'(!(win && rd)));
    chk("R7/R9 wr_n", int'(wr_n), int'(!(win && wr)));
    chk("R3/R4/R6/R7 ad_oe", int'(ad_oe), int'(e_oe));
    if (e_oe) begin
      e_out = (wr && m_t >= 2 * CPS - 1) ? m_wd : (m_kind == 1 ? m_pa & 255 : m_da);
      chk("R3/R6/R7 ad_out", int'(ad_out), e_out);
    end
    chk("R3/R4/R5 hi_oe", int'(hi_oe), int'(run && ef));
    if (run && ef) chk("R3 hi_addr", int'(hi_addr), (m_pa >> 8) & 15);
    chk("R6 rd_valid", int'(rd_valid), int'(m_rdv));
    chk("R6 rd_data", int'(rd_data), m_rdd);
  endtask

  task automatic capture();
    if (sidx < NS) begin
      m_kind = s_kind[sidx]; m_pa = s_pa[sidx]; m_da = s_da[sidx];
      m_wd = s_wd[sidx]; m_last = s_last[sidx] != 0; m_ext = s_ext[sidx] != 0;
      sidx++;
    end else begin
      m_kind = 0; m_last = 1'b0; m_ext = 1'b0;
    end
  endtask

  task automatic model_step();
    bit smp;
    smp = !m_halt && m_t == 4 * CPS - 1 && (ext_f() || m_kind == 2);
    if (smp) m_rdd = int'(ad_in);
    m_rdv = smp;
    if (m_halt) begin
      if (step_n) begin m_halt = 1'b0; capture(); end
    end else if (m_t == MC - 1) begin
      m_t = 0;
      if (!step_n && m_last) begin m_halt = 1'b1; m_kind = 0; end
      else capture();
    end else m_t++;
  endtask

  initial begin
    add(0, 1, 'h5A3, 0, 0, 0, 0);
    add(1, 1, 'h123, 0, 0, 0, 0);
    add(2, 1, 'h123, 0, 0, 0, 1);
    add(3, 2, 0, 'h3C, 0, 0, 0);
    add(4, 3, 0, 'h81, 'hE7, 0, 0);
    add(5, 0, 0, 0, 0, 0, 0);
    add(6, 1, 'h3FF, 0, 0, 0, 0);
    add(7, 1, 'h400, 0, 0, 0, 0);
    add(8, 3, 0, 'h10, 'h5A, 0, 0);
    add(9, 2, 0, 'hF0, 0, 0, 0);
    add(10, 1, 'h9C4, 0, 0, 1, 0);
    add(11, 2, 0, 'h22, 0, 1, 0);
    add(12, 3, 0, 'h33, 'hC3, 1, 0);
    add(13, 1, 'hFFF, 0, 0, 1, 1);
    rst_n = 1'b0;
    drive();
    repeat (3) @(negedge clk);
    #1;
    chk("R10 pstore_n", int'(pstore_n), 1);
    chk("R10 rd_n", int'(rd_n), 1);
    chk("R10 wr_n", int'(wr_n), 1);
    chk("R10 ad_oe", int'(ad_oe), 0);
    chk("R10 hi_oe", int'(hi_oe), 0);
    chk("R10 take", int'(take), 0);
    chk("R10 held", int'(held), 0);
    chk("R10 rd_valid", int'(rd_valid), 0);
    m_t = 0; m_kind = 0; m_pa = 0; m_da = 0; m_wd = 0; m_rdd = 0;
    m_halt = 1'b0; m_last = 1'b0; m_ext = 1'b0; m_rdv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < RUN_CYCLES; i++) begin
      drive();
      #1;
      compare();
      @(posedge clk);
      model_step();
      @(negedge clk);
      cyc++;
    end
    if (sidx != NS) chk("R2 all requests taken", sidx, NS);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cyc=%0d actual=hung expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule